// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates among five hardware interrupt request lines on behalf of a CPU core. Each line has its own trigger rule. The non-maskable line needs a rising edge and must then stay high. The edge line sets a sticky latch on each rising edge. The remaining three lines request service only while they are held high. The block applies per-source masks and one global enable, then picks the highest-priority eligible source. It shows the core a live pending flag.

At an instruction boundary the core pulses a take strobe. The block then registers the selected source code and its 16-bit vector address, and holds them until the next accepted take. Taking a request clears the global enable. When the taken source is the non-vectored one, the block pulls an active-low acknowledge low for one cycle, so that the external device can supply the target.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `src_o` is 0, `vec_o` is 0x0000, `ext_ack_n_o` is 1, the global enable is cleared, all three mask bits are set, and the edge latch is empty. Only the non-maskable line can raise `pending_o`.
- R2: Among eligible sources the winner is fixed, from highest to lowest: non-maskable (code 1), edge (code 2), level A (code 3), level B (code 4), external (code 5).
- R3: The registered vector is 0x0024 for code 1, 0x003C for code 2, 0x0034 for code 3, 0x002C for code 4 and 0x0000 for code 5. Each is the source's RST value times 8.
- R4: The non-maskable line ignores masks and the global enable. It becomes pending one clock after a low-to-high change and stays pending only while the pin is high. A pin already high when reset is released does not count as a change. After it is taken, a new request needs the pin to go low and then high again.
- R5: A rising edge on `edge_pin_i` sets a latch even while that source is masked or disabled. The latch stays set after the pin falls, until that source is taken or reset is applied. A pin held high after the take does not set it again.
- R6: Level A, level B and external request service only while their pins are high.
- R7: `mask_wr_i` loads `mask_data_i`. Bit 2 masks the edge source, bit 1 masks level A and bit 0 masks level B; a 1 means masked. The external source has no mask bit.
- R8: `en_set_i` sets the global enable and `en_clr_i` clears it; when both are high, clear wins. An accepted take clears the enable, even with `en_set_i` high in the same cycle. A cleared enable blocks every source except the non-maskable one.
- R9: A take with `pending_o` high loads `src_o` and `vec_o` at that clock edge. The two outputs then hold until the next accepted take. A take with `pending_o` low changes nothing.
- R10: `ext_ack_n_o` is low for exactly the one cycle after the external source (code 5) is taken, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_pin_i | input | 1 | Non-maskable request line (edge and level) |
| edge_pin_i | input | 1 | Rising-edge request line, latched |
| lvl_a_pin_i | input | 1 | Level request line A |
| lvl_b_pin_i | input | 1 | Level request line B |
| ext_pin_i | input | 1 | Non-vectored level request line |
| take_i | input | 1 | Core accepts the pending request this cycle |
| mask_wr_i | input | 1 | Load strobe for the mask bits |
| mask_data_i | input | 3 | Mask value: bit2 edge, bit1 level A, bit0 level B |
| en_set_i | input | 1 | Set the global enable |
| en_clr_i | input | 1 | Clear the global enable |
| pending_o | output | 1 | An eligible request exists |
| src_o | output | 3 | Code of the last taken source (0 = none) |
| vec_o | output | 16 | Vector address of the last taken source |
| ext_ack_n_o | output | 1 | Active-low acknowledge for the external source |

## Verification
The hardest case to reach is a mix of stored state and live pins. The edge latch is loaded while its source is masked and disabled, and it is only revealed later, together with a non-maskable request that is still held high. The stimulus raises both lines in the same cycle while everything else is blocked. It takes the non-maskable request first, then unmasks and re-enables to draw out the latched edge. Throughout, the pin stays high to show that the non-maskable line does not fire again. Reset is also applied over a loaded latch, to show that reset empties it.

// File: rtl/vic_pkg.sv
// Shared constants and helpers for the vectored interrupt controller.
// Assumes index 0 is the highest priority and the last index is the external line.
package vic_pkg;
    localparam int unsigned NUM_SRC = 5;
    localparam int unsigned SRC_W   = $clog2(NUM_SRC + 1);
    localparam int unsigned IDX_W   = $clog2(NUM_SRC);
    localparam int unsigned VEC_W   = 16;
    localparam int unsigned MASK_W  = 3;
    localparam int unsigned EXT_IDX = NUM_SRC - 1;

    typedef enum logic [1:0] {
        TRIG_EDGE_HOLD   = 2'd0,
        TRIG_STICKY_RISE = 2'd1,
        TRIG_LEVEL       = 2'd2
    } trig_e;

    // Trigger rule per priority index
    function automatic trig_e trig_of(input int unsigned idx);
        if (idx == 0) return TRIG_EDGE_HOLD;
        if (idx == 1) return TRIG_STICKY_RISE;
        return TRIG_LEVEL;
    endfunction

    // Sources that carry their own mask bit
    function automatic bit has_mask(input int unsigned idx);
        return (idx >= 1) && (idx <= MASK_W);
    endfunction

    // Mask bit position for a masked source (edge -> 2, level A -> 1, level B -> 0)
    function automatic int unsigned mask_pos(input int unsigned idx);
        return MASK_W - idx;
    endfunction

    // Vector address: RST value times 8, computed from half-unit RST values times 4
    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        int unsigned half_units;
        case (idx)
            IDX_W'(0): half_units = 9;
            IDX_W'(1): half_units = 15;
            IDX_W'(2): half_units = 13;
            IDX_W'(3): half_units = 11;
            default:   half_units = 0;
        endcase
        return VEC_W'(half_units * 4);
    endfunction
endpackage

// File: rtl/irq_cond.sv
// Conditions one edge-based request line into a request flag.
// MODE selects the edge-and-hold rule (flag also needs the pin high) or the
// sticky rising-edge latch. Level lines do not use this module.
// Assumes pin_i is already synchronous to clk.
module irq_cond
    import vic_pkg::*;
#(
    parameter trig_e MODE = TRIG_STICKY_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic clr_i,
    output logic req_o
);
    logic prev_q;
    logic latch_q;
    logic rise;

    assign rise = pin_i & ~prev_q;

    // Previous pin value; reset high so a pin held high at reset release is no edge
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_i;
    end

    generate
        if (MODE == TRIG_EDGE_HOLD) begin : g_hold
            // Edge latch that is dropped by a take or by the pin falling
            always_ff @(posedge clk) begin
                if (!rst_n)               latch_q <= 1'b0;
                else if (rise)            latch_q <= 1'b1;
                else if (clr_i || !pin_i) latch_q <= 1'b0;
            end
            assign req_o = latch_q & pin_i;
        end else begin : g_sticky
            // Edge latch held until taken or reset
            always_ff @(posedge clk) begin
                if (!rst_n)     latch_q <= 1'b0;
                else if (rise)  latch_q <= 1'b1;
                else if (clr_i) latch_q <= 1'b0;
            end
            assign req_o = latch_q;
        end
    endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: the lowest set index wins.
// Produces a one-hot grant, a valid flag and the winning index.
module irq_prio_pick #(
    parameter int unsigned N = 5,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);
    // Scan from lowest priority upward so the highest priority is written last
    always_comb begin
        grant_o = '0;
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                valid_o    = 1'b1;
                idx_o      = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
// Top of the prioritized vectored interrupt controller.
// Conditions five request lines and gates them with masks and a global enable.
// Picks a winner by fixed priority and registers its code and vector on a take.
// Assumes all inputs are synchronous to clk.
module vec_irq_ctrl
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pin_i,
    input  logic              edge_pin_i,
    input  logic              lvl_a_pin_i,
    input  logic              lvl_b_pin_i,
    input  logic              ext_pin_i,
    input  logic              take_i,
    input  logic              mask_wr_i,
    input  logic [MASK_W-1:0] mask_data_i,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    output logic              pending_o,
    output logic [SRC_W-1:0]  src_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              ext_ack_n_o
);
    logic [NUM_SRC-1:0] pin_vec;
    logic [NUM_SRC-1:0] raw_req;
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] grant;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    logic               accept;
    logic               ien_q;
    logic [MASK_W-1:0]  mask_q;
    logic [SRC_W-1:0]   src_q;
    logic [VEC_W-1:0]   vec_q;
    logic               ack_n_q;

    assign pin_vec = {ext_pin_i, lvl_b_pin_i, lvl_a_pin_i, edge_pin_i, nmi_pin_i};
    assign accept  = take_i & win_valid;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            // Trigger conditioning chosen by the source's rule
            if (trig_of(g) == TRIG_LEVEL) begin : g_lvl
                assign raw_req[g] = pin_vec[g];
            end else begin : g_edge
                irq_cond #(.MODE(trig_of(g))) cond_i (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .pin_i (pin_vec[g]),
                    .clr_i (accept & grant[g]),
                    .req_o (raw_req[g])
                );
            end
            // Eligibility: the non-maskable line is never gated
            if (g == 0) begin : g_nm
                assign elig[g] = raw_req[g];
            end else if (has_mask(g)) begin : g_msk
                assign elig[g] = raw_req[g] & ien_q & ~mask_q[mask_pos(g)];
            end else begin : g_unm
                assign elig[g] = raw_req[g] & ien_q;
            end
        end
    endgenerate

    irq_prio_pick #(.N(NUM_SRC)) pick_i (
        .req_i   (elig),
        .grant_o (grant),
        .valid_o (win_valid),
        .idx_o   (win_idx)
    );

    // Global enable: take clears first, then clear command, then set command
    always_ff @(posedge clk) begin
        if (!rst_n)        ien_q <= 1'b0;
        else if (accept)   ien_q <= 1'b0;
        else if (en_clr_i) ien_q <= 1'b0;
        else if (en_set_i) ien_q <= 1'b1;
    end

    // Mask bits, all masked out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '1;
        else if (mask_wr_i) mask_q <= mask_data_i;
    end

    // Capture the winner's code and vector on an accepted take
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            vec_q <= '0;
        end else if (accept) begin
            src_q <= SRC_W'(win_idx) + SRC_W'(1);
            vec_q <= vec_of(win_idx);
        end
    end

    // One-cycle active-low acknowledge after the external line is taken
    always_ff @(posedge clk) begin
        if (!rst_n) ack_n_q <= 1'b1;
        else        ack_n_q <= ~(accept && (win_idx == IDX_W'(EXT_IDX)));
    end

    assign pending_o   = win_valid;
    assign src_o       = src_q;
    assign vec_o       = vec_q;
    assign ext_ack_n_o = ack_n_q;
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
// Property checker for vec_irq_ctrl, attached by bind.
// Watches ports plus the enable register and the picker's grant.
module vec_irq_ctrl_chk
    import vic_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               take_i,
    input logic               pending_o,
    input logic [SRC_W-1:0]   src_o,
    input logic [VEC_W-1:0]   vec_o,
    input logic               ext_ack_n_o,
    input logic               ien,
    input logic [NUM_SRC-1:0] grant
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (src_o == '0) && (vec_o == '0) && ext_ack_n_o && !ien);

    // R2
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o |-> ($countones(grant) == 1));

    // R3
    edge_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_o == SRC_W'(2)) |-> (vec_o == VEC_W'(16'h003C)));

    // R3
    nmi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_o == SRC_W'(1)) |-> (vec_o == VEC_W'(16'h0024)));

    // R8
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !ien) |-> grant[0]);

    // R8
    take_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && pending_o) |=> !ien);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_i && pending_o) |=> ($stable(src_o) && $stable(vec_o)));

    // R10
    ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_ack_n_o |-> (src_o == SRC_W'(EXT_IDX + 1)));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take_i),
    .pending_o   (pending_o),
    .src_o       (src_o),
    .vec_o       (vec_o),
    .ext_ack_n_o (ext_ack_n_o),
    .ien         (ien_q),
    .grant       (grant)
);

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_pin = 1'b0, edge_pin = 1'b0, lvl_a = 1'b0, lvl_b = 1'b0, ext_pin = 1'b0;
    logic        take = 1'b0, mask_wr = 1'b0, en_set = 1'b0, en_clr = 1'b0;
    logic [2:0]  mask_data = 3'b000;
    logic        pending;
    logic [2:0]  src;
    logic [15:0] vec;
    logic        ack_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vec_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .nmi_pin_i(nmi_pin), .edge_pin_i(edge_pin), .lvl_a_pin_i(lvl_a),
        .lvl_b_pin_i(lvl_b), .ext_pin_i(ext_pin), .take_i(take),
        .mask_wr_i(mask_wr), .mask_data_i(mask_data),
        .en_set_i(en_set), .en_clr_i(en_clr),
        .pending_o(pending), .src_o(src), .vec_o(vec), .ext_ack_n_o(ack_n)
    );

    // Table entry: {mask[2:0], req{lvl_a,lvl_b,ext}[2:0], exp_pending, exp_src[2:0]}
    localparam int NT = 10;
    localparam logic [9:0] TBL [NT] = '{
        {3'b000, 3'b100, 1'b1, 3'd3},
        {3'b000, 3'b010, 1'b1, 3'd4},
        {3'b000, 3'b001, 1'b1, 3'd5},
        {3'b000, 3'b111, 1'b1, 3'd3},
        {3'b000, 3'b011, 1'b1, 3'd4},
        {3'b010, 3'b110, 1'b1, 3'd4},
        {3'b011, 3'b111, 1'b1, 3'd5},
        {3'b011, 3'b110, 1'b0, 3'd0},
        {3'b001, 3'b011, 1'b1, 3'd5},
        {3'b000, 3'b000, 1'b0, 3'd0}
    };

    function automatic logic [15:0] exp_vec(input logic [2:0] s);
        case (s)
            3'd1: return 16'h0024;
            3'd2: return 16'h003C;
            3'd3: return 16'h0034;
            3'd4: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_take();
        take = 1'b1;
        cyc();
        take = 1'b0;
    endtask

    task automatic do_enable();
        en_set = 1'b1;
        cyc();
        en_set = 1'b0;
    endtask

    task automatic do_disable();
        en_clr = 1'b1;
        cyc();
        en_clr = 1'b0;
    endtask

    task automatic do_mask(input logic [2:0] m);
        mask_data = m;
        mask_wr = 1'b1;
        cyc();
        mask_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc();
        cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] last_src;
        #1;
        nmi_pin = 1'b1;          // held high across reset: no edge afterwards
        do_reset();

        // R1 reset state
        chk(src == 3'd0, "R1 src after reset", src, 0);
        chk(vec == 16'h0, "R1 vec after reset", vec, 0);
        chk(ack_n == 1'b1, "R1 ack after reset", ack_n, 1);
        chk(pending == 1'b0, "R4 nmi high at reset release not pending", pending, 0);
        lvl_a = 1'b1;
        settle();
        chk(pending == 1'b0, "R1 level blocked after reset", pending, 0);
        lvl_a = 1'b0;
        nmi_pin = 1'b0;
        cyc();

        // Table walk over level sources and masks (R2 R3 R6 R7 R9 R10)
        last_src = 3'd0;
        for (int i = 0; i < NT; i++) begin
            do_enable();
            do_mask(TBL[i][9:7]);
            {lvl_a, lvl_b, ext_pin} = TBL[i][6:4];
            settle();
            chk(pending == TBL[i][3], $sformatf("R2 R7 pending row %0d", i), pending, TBL[i][3]);
            do_take();
            if (TBL[i][3]) begin
                chk(src == TBL[i][2:0], $sformatf("R2 src row %0d", i), src, TBL[i][2:0]);
                chk(vec == exp_vec(TBL[i][2:0]), $sformatf("R3 vec row %0d", i), vec, exp_vec(TBL[i][2:0]));
                last_src = TBL[i][2:0];
            end else begin
                chk(src == last_src, $sformatf("R9 idle take row %0d", i), src, last_src);
            end
            chk(ack_n == (last_src != 3'd5 || !TBL[i][3]), $sformatf("R10 ack row %0d", i),
                ack_n, (last_src != 3'd5 || !TBL[i][3]));
            {lvl_a, lvl_b, ext_pin} = 3'b000;
            cyc();
            chk(ack_n == 1'b1, $sformatf("R10 ack released row %0d", i), ack_n, 1);
        end

        // R6 level drops out when pin falls
        do_enable();
        do_mask(3'b000);
        lvl_b = 1'b1;
        settle();
        chk(pending == 1'b1, "R6 level high pends", pending, 1);
        lvl_b = 1'b0;
        settle();
        chk(pending == 1'b0, "R6 level low idle", pending, 0);

        // R5 edge latched while masked and disabled
        do_disable();
        do_mask(3'b111);
        edge_pin = 1'b1;
        cyc();
        edge_pin = 1'b0;
        cyc();
        chk(pending == 1'b0, "R5 masked edge hidden", pending, 0);
        do_mask(3'b011);
        do_enable();
        chk(pending == 1'b1, "R5 latched edge revealed", pending, 1);
        do_take();
        chk(src == 3'd2, "R2 edge src", src, 2);
        chk(vec == 16'h003C, "R3 edge vec", vec, 16'h003C);
        do_enable();
        chk(pending == 1'b0, "R5 latch cleared by take", pending, 0);

        // R5 held-high pin does not re-request
        edge_pin = 1'b1;
        cyc();
        chk(pending == 1'b1, "R5 new edge pends", pending, 1);
        do_take();
        do_enable();
        chk(pending == 1'b0, "R5 held pin no repeat", pending, 0);
        edge_pin = 1'b0;
        cyc();

        // R4 R2 non-maskable beats edge while everything else is blocked
        do_disable();
        do_mask(3'b111);
        nmi_pin = 1'b1;
        edge_pin = 1'b1;
        cyc();
        chk(pending == 1'b1, "R4 nmi pends while disabled", pending, 1);
        do_take();
        chk(src == 3'd1, "R2 nmi wins", src, 1);
        chk(vec == 16'h0024, "R3 nmi vec", vec, 16'h0024);
        do_enable();
        do_mask(3'b011);
        chk(pending == 1'b1, "R5 edge still latched", pending, 1);
        do_take();
        chk(src == 3'd2, "R2 edge after nmi", src, 2);
        do_enable();
        chk(pending == 1'b0, "R4 held nmi no repeat", pending, 0);
        nmi_pin = 1'b0;
        cyc();
        nmi_pin = 1'b1;
        cyc();
        chk(pending == 1'b1, "R4 nmi re-armed", pending, 1);
        do_take();
        chk(src == 3'd1, "R4 nmi retaken", src, 1);
        nmi_pin = 1'b0;
        edge_pin = 1'b0;
        cyc();

        // R4 nmi dropping before take
        nmi_pin = 1'b1;
        cyc();
        chk(pending == 1'b1, "R4 nmi pulse pends", pending, 1);
        nmi_pin = 1'b0;
        settle();
        chk(pending == 1'b0, "R4 nmi fall drops", pending, 0);
        cyc();
        nmi_pin = 1'b1;
        settle();
        chk(pending == 1'b0, "R4 no pend before edge registered", pending, 0);
        nmi_pin = 1'b0;
        cyc();

        // R8 clear wins over set
        do_mask(3'b000);
        lvl_a = 1'b1;
        en_set = 1'b1;
        en_clr = 1'b1;
        cyc();
        en_set = 1'b0;
        en_clr = 1'b0;
        chk(pending == 1'b0, "R8 clear beats set", pending, 0);
        do_take();
        chk(src == 3'd1, "R9 take without pending ignored", src, 1);

        // R8 accepted take beats same-cycle set
        do_enable();
        take = 1'b1;
        en_set = 1'b1;
        cyc();
        take = 1'b0;
        en_set = 1'b0;
        chk(src == 3'd3, "R2 level A taken", src, 3);
        chk(pending == 1'b0, "R8 take beats set", pending, 0);

        // R9 outputs hold while inputs move
        ext_pin = 1'b1;
        lvl_b = 1'b1;
        cyc();
        do_enable();
        cyc();
        chk(src == 3'd3 && vec == 16'h0034, "R9 hold without take", src, 3);
        {lvl_a, lvl_b, ext_pin} = 3'b000;
        do_disable();

        // R1 R5 R7 reset empties the edge latch and restores masks
        edge_pin = 1'b1;
        cyc();
        edge_pin = 1'b0;
        cyc();
        do_reset();
        chk(src == 3'd0, "R1 src cleared by reset", src, 0);
        do_enable();
        lvl_a = 1'b1;
        settle();
        chk(pending == 1'b0, "R7 masked after reset", pending, 0);
        do_mask(3'b011);
        chk(pending == 1'b0, "R1 R5 latch cleared by reset", pending, 0);
        ext_pin = 1'b1;
        settle();
        chk(pending == 1'b1, "R7 external has no mask", pending, 1);
        do_take();
        chk(src == 3'd5, "R10 external taken", src, 5);
        chk(ack_n == 1'b0, "R10 ack low", ack_n, 0);
        {lvl_a, ext_pin} = 2'b00;
        cyc();
        chk(ack_n == 1'b1, "R10 ack one cycle", ack_n, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule